// File: doc/BRIEF.md
# Handshaked Spectrum Sample Receiver

This block takes frequency-domain samples from a shared 8-bit parallel bus. Two upstream units can drive the bus, one at a time. Each has its own transmit-request line and its own word-ready strobe. The receiver answers every word with a single acknowledge line and holds it until the sender withdraws its ready strobe.

The bus carries each sample as two unsigned bytes: the real part first, then the imaginary part. When the second byte of a pair arrives, the block outputs the squared magnitude of the sample as a 17-bit value. A one-cycle strobe marks the new value, and it is tagged with the identity of the sender. An activity flag tells downstream averaging logic that a transfer is in progress.

When both request lines go low, the block waits a fixed quiet period before it accepts a new transfer. Every bus input goes through a two-flop synchronizer before the controller uses it. The whole block runs on one clock with a synchronous, active-high reset.

Top module: `specrx_top`

## Requirements
- R1: A transfer starts only when exactly one request line is high. With both request lines high, the block stays inactive (`active` low). In the waiting state, with both lines high, ready strobes cause no acknowledge.
- R2: The ready strobe that counts is the one belonging to the sender whose request line is high. `rdy_a` is used for `req_a` and `rdy_b` for `req_b`. The other sender's ready line is ignored.
- R3: When the relevant ready strobe is seen high, `ack` goes high. It stays high while that ready strobe stays high, and goes low once it falls. The block then waits for the next word.
- R4: Words within a transfer are paired by a word counter that is cleared at the start of every transfer. An even word (counter LSB 0) is stored as the real part. An odd word (LSB 1) is the imaginary part.
- R5: On an odd word, `mag` becomes real*real + imag*imag, with both parts unsigned 8-bit. `mag_vld` is high for exactly the first cycle in which `ack` is high. On even words, `mag_vld` stays low.
- R6: `active` is high while the block waits for words or acknowledges them. It is low when idle and during the quiet period.
- R7: Once both request lines are seen low while waiting, `active` falls. The block then spends 16 cycles (`TAIL_CYC`) in the quiet period and ignores any request during it. Suppose a request is raised in the cycle after `active` falls. Then `active` rises again on the 17th clock edge after the one where it fell.
- R8: `sender_id` is 0 for a transfer requested on `req_a` and 1 for one on `req_b`. It is registered when the transfer starts and holds through the transfer and the quiet period.
- R9: After reset, `ack`, `active`, `mag_vld`, `mag` and `sender_id` are all zero.
- R10: Request and ready inputs pass through two flip-flops. A ready strobe raised between clock edges produces `ack` on the third rising edge after it was raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_a | input | 1 | Transfer request from sender A |
| req_b | input | 1 | Transfer request from sender B |
| rdy_a | input | 1 | Word-ready strobe of sender A |
| rdy_b | input | 1 | Word-ready strobe of sender B |
| bus_data | input | 8 | Shared data bus |
| ack | output | 1 | Word acknowledge |
| active | output | 1 | Transfer in progress |
| sender_id | output | 1 | 0 = sender A, 1 = sender B |
| mag | output | 17 | Squared magnitude of the last complete pair |
| mag_vld | output | 1 | One-cycle strobe: `mag` updated |

## Verification
The word counter is hidden, so a wrong value shows up one pair later. It makes the next `mag` come out as an odd word's square or a cross term, or makes `mag_vld` fire on the wrong handshake. A counter that is not cleared between transfers is visible at the first pair of the following transfer. A controller stuck in the wrong state shows within three cycles of a ready edge, as a missing or stuck `ack`. A quiet-period count that is off by one moves the rise of `active` by that cycle, and the bench measures that cycle exactly.

// File: rtl/specrx_pkg.sv
package specrx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_READ = 2'd2,
        ST_TAIL = 2'd3
    } rx_state_e;
endpackage

// File: rtl/specrx_sync.sv
module specrx_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] st1_q;
    logic [WIDTH-1:0] st2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st1_q <= '0;
            st2_q <= '0;
        end else begin
            st1_q <= din;
            st2_q <= st1_q;
        end
    end

    assign dout = st2_q;
endmodule

// File: rtl/specrx_sq.sv
module specrx_sq #(
    parameter int DW = 8,
    localparam int MW = 2 * DW + 1
) (
    input  logic [DW-1:0] re,
    input  logic [DW-1:0] im,
    output logic [MW-1:0] sum
);
    logic [2*DW-1:0] re_sq;
    logic [2*DW-1:0] im_sq;

    always_comb begin
        re_sq = re * re;
        im_sq = im * im;
        sum   = {1'b0, re_sq} + {1'b0, im_sq};
    end
endmodule

// File: rtl/specrx_ctrl.sv
module specrx_ctrl
    import specrx_pkg::*;
#(
    parameter int DW       = 8,
    parameter int CNT_W    = 11,
    parameter int TAIL_CYC = 16,
    localparam int MW      = 2 * DW + 1,
    localparam int TW      = $clog2(TAIL_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          s_req_a,
    input  logic          s_req_b,
    input  logic          s_rdy_a,
    input  logic          s_rdy_b,
    input  logic [DW-1:0] data,
    output logic          ack,
    output logic          active,
    output logic          sender_id,
    output logic [MW-1:0] mag,
    output logic          mag_vld
);
    typedef struct packed {
        rx_state_e      state;
        logic [CNT_W-1:0] cnt;
        logic [TW-1:0]  tail;
        logic [DW-1:0]  re;
        logic [MW-1:0]  mag;
        logic           mag_vld;
        logic           id;
    } regs_t;

    regs_t r_q, r_d;
    logic  one_req;
    logic  sel_rdy;
    logic  held_rdy;
    logic [MW-1:0] sq_sum;

    specrx_sq #(.DW(DW)) u_sq (
        .re  (r_q.re),
        .im  (data),
        .sum (sq_sum)
    );

    always_comb begin
        r_d         = r_q;
        r_d.mag_vld = 1'b0;
        one_req     = s_req_a ^ s_req_b;
        sel_rdy     = one_req && (s_req_a ? s_rdy_a : s_rdy_b);
        held_rdy    = r_q.id ? s_rdy_b : s_rdy_a;
        case (r_q.state)
            ST_IDLE: begin
                if (one_req) begin
                    r_d.state = ST_WAIT;
                    r_d.id    = s_req_b;
                    r_d.cnt   = '0;
                end
            end
            ST_WAIT: begin
                if (!s_req_a && !s_req_b) begin
                    r_d.state = ST_TAIL;
                    r_d.tail  = '0;
                end else if (sel_rdy) begin
                    r_d.state = ST_READ;
                    r_d.cnt   = r_q.cnt + 1'b1;
                    if (!r_q.cnt[0]) begin
                        r_d.re = data;
                    end else begin
                        r_d.mag     = sq_sum;
                        r_d.mag_vld = 1'b1;
                    end
                end
            end
            ST_READ: begin
                if (!held_rdy) r_d.state = ST_WAIT;
            end
            default: begin
                if (r_q.tail == TW'(TAIL_CYC - 1)) r_d.state = ST_IDLE;
                else r_d.tail = r_q.tail + 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ack       = (r_q.state == ST_READ);
    assign active    = (r_q.state == ST_WAIT) || (r_q.state == ST_READ);
    assign sender_id = r_q.id;
    assign mag       = r_q.mag;
    assign mag_vld   = r_q.mag_vld;

    // R1: two simultaneous requests never start a transfer
    p_both_req_idle_r1: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_IDLE && s_req_a && s_req_b) |=> (r_q.state == ST_IDLE));

    // R3: acknowledge only rises after the selected ready was seen
    p_ack_after_rdy_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> $past(sel_rdy));

    // R5: the magnitude strobe lasts one cycle
    p_vld_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        mag_vld |=> !mag_vld);

    // R5: the strobe coincides with the start of an acknowledge
    p_vld_with_ack_r5: assert property (@(posedge clk) disable iff (rst)
        mag_vld |-> $rose(ack));

    // R6: acknowledge implies activity
    p_ack_active_r6: assert property (@(posedge clk) disable iff (rst)
        ack |-> active);

    // R8: sender identity holds while active
    p_id_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active)) |-> $stable(sender_id));

    // R5: squared magnitude of two bytes stays in range
    p_mag_range_r5: assert property (@(posedge clk) disable iff (rst)
        mag_vld |-> (mag <= MW'(2 * ((1 << DW) - 1) * ((1 << DW) - 1))));
endmodule

// File: rtl/specrx_top.sv
module specrx_top #(
    parameter int DW       = 8,
    parameter int CNT_W    = 11,
    parameter int TAIL_CYC = 16,
    localparam int MW      = 2 * DW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_a,
    input  logic          req_b,
    input  logic          rdy_a,
    input  logic          rdy_b,
    input  logic [DW-1:0] bus_data,
    output logic          ack,
    output logic          active,
    output logic          sender_id,
    output logic [MW-1:0] mag,
    output logic          mag_vld
);
    logic [3:0] raw_ctl;
    logic [3:0] syn_ctl;

    assign raw_ctl = {req_a, req_b, rdy_a, rdy_b};

    specrx_sync #(.WIDTH(4)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_ctl),
        .dout (syn_ctl)
    );

    specrx_ctrl #(
        .DW       (DW),
        .CNT_W    (CNT_W),
        .TAIL_CYC (TAIL_CYC)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .s_req_a   (syn_ctl[3]),
        .s_req_b   (syn_ctl[2]),
        .s_rdy_a   (syn_ctl[1]),
        .s_rdy_b   (syn_ctl[0]),
        .data      (bus_data),
        .ack       (ack),
        .active    (active),
        .sender_id (sender_id),
        .mag       (mag),
        .mag_vld   (mag_vld)
    );
endmodule

// File: tb/sim_specrx_top.sv
module sim_specrx_top;
    localparam int TAIL = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_a = 1'b0, req_b = 1'b0, rdy_a = 1'b0, rdy_b = 1'b0;
    logic [7:0]  bus_data = '0;
    logic        ack, active, sender_id, mag_vld;
    logic [16:0] mag;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    specrx_top #(.TAIL_CYC(TAIL)) u0 (
        .clk(clk), .rst(rst), .req_a(req_a), .req_b(req_b),
        .rdy_a(rdy_a), .rdy_b(rdy_b), .bus_data(bus_data),
        .ack(ack), .active(active), .sender_id(sender_id),
        .mag(mag), .mag_vld(mag_vld)
    );

    function automatic int exp_mag(input int re, input int im);
        return re * re + im * im;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic begin_xfer(input bit use_b);
        int n;
        if (use_b) req_b = 1'b1; else req_a = 1'b1;
        n = 0;
        while (!active && n < 40) begin @(negedge clk); n++; end
        chk(active, "R6", active, 1);
        chk(sender_id == use_b, "R8", sender_id, use_b);
    endtask

    task automatic end_xfer();
        int n;
        req_a = 1'b0; req_b = 1'b0;
        n = 0;
        while (active && n < 40) begin @(negedge clk); n++; end
        chk(!active, "R7", active, 0);
    endtask

    // one handshake; odd words carry the imaginary part
    task automatic send_word(input bit use_b, input logic [7:0] d,
                             input bit odd, input int expv);
        int n;
        bus_data = d;
        if (use_b) rdy_b = 1'b1; else rdy_a = 1'b1;
        n = 0;
        while (!ack && n < 20) begin @(negedge clk); n++; end
        chk(n == 3, "R10", n, 3);
        chk(ack, "R3", ack, 1);
        chk(mag_vld == odd, "R5", mag_vld, odd);
        if (odd) chk(mag == 17'(expv), "R4", int'(mag), expv);
        @(negedge clk);
        chk(!mag_vld, "R5", mag_vld, 0);
        chk(ack, "R3", ack, 1);
        rdy_a = 1'b0; rdy_b = 1'b0;
        n = 0;
        while (ack && n < 20) begin @(negedge clk); n++; end
        chk(!ack, "R3", ack, 0);
    endtask

    task automatic send_pair(input bit use_b, input int re, input int im);
        send_word(use_b, 8'(re), 1'b0, 0);
        send_word(use_b, 8'(im), 1'b1, exp_mag(re, im));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int c;
        void'($urandom(32'h5EED1234));
        step(3);
        // R9: reset values
        chk(!ack && !active && !mag_vld && mag == 0 && !sender_id, "R9",
            int'({ack, active, mag_vld, sender_id}), 0);
        rst = 1'b0;
        step(2);

        // R1: both requests high never start a transfer
        req_a = 1'b1; req_b = 1'b1;
        step(10);
        chk(!active, "R1", active, 0);
        req_b = 1'b0;
        begin_xfer(1'b0);
        // R1: both high while waiting, ready ignored
        req_b = 1'b1; step(4);
        rdy_a = 1'b1; bus_data = 8'd77;
        step(8);
        chk(!ack, "R1", ack, 0);
        rdy_a = 1'b0; req_b = 1'b0;
        step(4);

        // R4 R5: directed corners then random pairs from sender A
        send_pair(1'b0, 0, 0);
        send_pair(1'b0, 255, 255);
        send_pair(1'b0, 255, 0);
        send_pair(1'b0, 3, 4);
        for (int i = 0; i < 20; i++)
            send_pair(1'b0, int'($urandom_range(0, 255)), int'($urandom_range(0, 255)));

        // R7: quiet period length measured at the ports
        req_a = 1'b0;
        c = 0;
        while (active && c < 40) begin @(negedge clk); c++; end
        req_b = 1'b1;
        c = 0;
        while (!active && c < 60) begin @(negedge clk); c++; end
        chk(c == TAIL + 1, "R7", c, TAIL + 1);
        chk(sender_id, "R8", sender_id, 1);

        // R2: sender A ready ignored during a sender B transfer
        rdy_a = 1'b1; bus_data = 8'd9;
        step(8);
        chk(!ack, "R2", ack, 0);
        rdy_a = 1'b0;
        step(4);
        for (int i = 0; i < 10; i++)
            send_pair(1'b1, int'($urandom_range(0, 255)), int'($urandom_range(0, 255)));
        end_xfer();
        // R8: identity held through quiet period
        step(3);
        chk(sender_id, "R8", sender_id, 1);
        step(TAIL);

        // R4: word counter cleared between transfers
        begin_xfer(1'b0);
        send_word(1'b0, 8'd9, 1'b0, 0);
        end_xfer();
        step(TAIL + 4);
        begin_xfer(1'b0);
        send_pair(1'b0, 5, 12);
        end_xfer();
        step(TAIL + 4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule